// File: doc/BRIEF.md
# Peripheral Clock Enable Controller

This block holds one clock-enable flag per on-chip peripheral and drives those flags out as a vector of enable lines toward the clock gating cells. Software reaches it through a simple single-cycle register bus with one strobe, a write flag, a byte address and 32-bit data. Reads return their data one cycle after the strobe.

The enable state is never written directly. Software turns peripherals on through a write-one-to-set alias and off through a write-one-to-clear alias, so any subset of enables can be changed atomically without a read-modify-write. A read-only status word reports the current enables. Two read-only availability words describe which peripherals and system options are present. Their contents are parameters, so a bench or an integrator can describe a reduced device. An enable whose peripheral is marked unavailable can never be set.

The enable output is a full 32-bit word. Reserved positions are tied to 0, so each implemented peripheral keeps the same line index as its status bit.

Top module: `periph_clk_en_ctrl`

## Requirements
- R1: Enable bits exist only at positions 0, 1, 2, 3, 6, 10, 11, 14, 16, 17, 20, 27, 28, 29 and 30 (mask 0x78134C4F). Every other enable bit reads 0, drives 0 and ignores writes.
- R2: After reset, the enable output and the status word are 0x00000001 (only bit 0 enabled), and the read data bus is 0.
- R3: The byte address map is: 0x00 availability word 0, 0x04 availability word 1, 0x08 enable status, 0x0C set alias, 0x10 clear alias. Reads of the set alias, the clear alias and any other address return 0.
- R4: A write to 0x0C turns on every available enable whose data bit is 1. Enables whose data bit is 0 are unchanged.
- R5: A write to 0x10 turns off every enable whose data bit is 1. Enables whose data bit is 0 are unchanged.
- R6: The enable output always equals the status word. It changes on the clock edge that accepts the set or clear write, and it is stable in every cycle without such a write.
- R7: Availability word 0 reads as the AVAIL0 parameter masked to the implemented positions of R1. By default every implemented position reads 1 (0x78134C4F).
- R8: Availability word 1 reads as the AVAIL1 parameter masked to these fields: flash size level at 31:30, SRAM size level at 29:28, CAN option at 18:17, radio option at 15:8, and three availability flags at 6, 5 and 4. All other bits read 0. The default value is 0xF006FF70.
- R9: An enable whose availability-word-0 bit is 0 cannot be set, and it always reads and drives 0.
- R10: Writes to 0x00, 0x04, 0x08 and to unmapped or unaligned addresses change no enable and no availability word.
- R11: Read data appears in the cycle after the read strobe and holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and register clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Single-cycle access strobe |
| busWrite | input | 1 | 1 for a write, 0 for a read |
| busAddr | input | 5 | Byte address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid the cycle after a read strobe |
| clkEnOut | output | 32 | Peripheral clock enables; reserved positions 0 |

## Verification
A corrupted enable flag appears on the enable output on the very edge that stores it, so the bench compares the output against its own model after every bus write. It also reads the status word back, and that read shows the same error one cycle later on the data bus. The bench walks a single set and a single clear across all 32 positions, including reserved and unavailable ones, so a wrong mask or a mis-decoded alias shows up at the first affected bit. An availability override in the bench separates the parameter from the implemented mask, so a swap of the two shows up on the first read of word 0.

// File: rtl/pce_pkg.sv
package pce_pkg;

  localparam int DATA_W = 32;

  // Implemented enable positions (also the default availability word 0)
  localparam logic [DATA_W-1:0] IMPL_MASK = 32'h7813_4C4F;

  // Defined fields of availability word 1 and their default contents
  localparam logic [DATA_W-1:0] AV1_MASK    = 32'hF006_FF70;
  localparam logic [DATA_W-1:0] AV1_DEFAULT = 32'hF006_FF70;

  localparam logic [DATA_W-1:0] EN_RESET = 32'h0000_0001;

  // Byte offsets of the register map
  localparam logic [7:0] OFS_AV0  = 8'h00;
  localparam logic [7:0] OFS_AV1  = 8'h04;
  localparam logic [7:0] OFS_STAT = 8'h08;
  localparam logic [7:0] OFS_SET  = 8'h0C;
  localparam logic [7:0] OFS_CLR  = 8'h10;

  typedef enum logic [1:0] {
    RD_AV0  = 2'd0,
    RD_AV1  = 2'd1,
    RD_STAT = 2'd2,
    RD_ZERO = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic   setStb;
    logic   clrStb;
    logic   rdStb;
    rdSel_e rdSel;
  } ctrlStb_t;

endpackage

// File: rtl/pce_ctrl.sv
module pce_ctrl
  import pce_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output ctrlStb_t          stb
);

  localparam int OFS_W = 8;

  logic [OFS_W-1:0] addrExt;
  logic             hitAv0;
  logic             hitAv1;
  logic             hitStat;
  logic             hitSet;
  logic             hitClr;

  // Full-width compare so unaligned addresses decode as unmapped
  always_comb begin
    addrExt = '0;
    addrExt[ADDR_W-1:0] = busAddr;
  end

  assign hitAv0  = (addrExt == OFS_AV0);
  assign hitAv1  = (addrExt == OFS_AV1);
  assign hitStat = (addrExt == OFS_STAT);
  assign hitSet  = (addrExt == OFS_SET);
  assign hitClr  = (addrExt == OFS_CLR);

  always_comb begin
    stb        = '0;
    stb.rdSel  = RD_ZERO;
    stb.setStb = busSel && busWrite && hitSet;
    stb.clrStb = busSel && busWrite && hitClr;
    stb.rdStb  = busSel && !busWrite;
    if (hitAv0)       stb.rdSel = RD_AV0;
    else if (hitAv1)  stb.rdSel = RD_AV1;
    else if (hitStat) stb.rdSel = RD_STAT;
  end

  // R3 / R10: at most one action per bus cycle
  a_r3_one_action: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.setStb, stb.clrStb, stb.rdStb}));

  // R10: no strobe without a bus access
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !busSel |-> (!stb.setStb && !stb.clrStb && !stb.rdStb));

endmodule

// File: rtl/pce_datapath.sv
module pce_datapath
  import pce_pkg::*;
#(
  parameter logic [DATA_W-1:0] AVAIL0 = IMPL_MASK,
  parameter logic [DATA_W-1:0] AVAIL1 = AV1_DEFAULT
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStb_t          stb,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] enOut
);

  localparam logic [DATA_W-1:0] AV0_WORD = AVAIL0 & IMPL_MASK;
  localparam logic [DATA_W-1:0] AV1_WORD = AVAIL1 & AV1_MASK;
  localparam logic [DATA_W-1:0] ALLOWED  = AV0_WORD;

  logic [DATA_W-1:0] setMask;
  logic [DATA_W-1:0] clrMask;
  logic [DATA_W-1:0] enReg;
  logic [DATA_W-1:0] rdNext;

  assign setMask = stb.setStb ? (wdata & ALLOWED) : '0;
  assign clrMask = stb.clrStb ? wdata : '0;

  // One flop per usable enable; reserved or unavailable positions are tied off
  for (genvar i = 0; i < DATA_W; i++) begin : g_en
    if (ALLOWED[i]) begin : g_flop
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)           enReg[i] <= EN_RESET[i];
        else if (setMask[i]) enReg[i] <= 1'b1;
        else if (clrMask[i]) enReg[i] <= 1'b0;
      end
    end else begin : g_tie
      assign enReg[i] = 1'b0;
    end
  end

  assign enOut = enReg;

  always_comb begin
    unique case (stb.rdSel)
      RD_AV0:  rdNext = AV0_WORD;
      RD_AV1:  rdNext = AV1_WORD;
      RD_STAT: rdNext = enReg;
      default: rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          rdata <= '0;
    else if (stb.rdStb) rdata <= rdNext;
  end

  // R1 / R9: nothing outside the usable mask is ever driven
  a_r9_unavail_zero: assert property (@(posedge clk) disable iff (!rstN)
    (enOut & ~ALLOWED) == '0);

  // R4: every requested available bit is on after the set write
  a_r4_set_takes: assert property (@(posedge clk) disable iff (!rstN)
    stb.setStb |=> ((enOut & $past(wdata) & ALLOWED) == ($past(wdata) & ALLOWED)));

  // R5: every requested bit is off after the clear write
  a_r5_clr_takes: assert property (@(posedge clk) disable iff (!rstN)
    stb.clrStb |=> ((enOut & $past(wdata)) == '0));

  // R6: enables hold when no alias is written
  a_r6_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.setStb && !stb.clrStb) |=> $stable(enOut));

  // R11: read data holds between reads
  a_r11_rd_hold: assert property (@(posedge clk) disable iff (!rstN)
    !stb.rdStb |=> $stable(rdata));

endmodule

// File: rtl/periph_clk_en_ctrl.sv
module periph_clk_en_ctrl
  import pce_pkg::*;
#(
  parameter int                ADDR_W = 5,
  parameter logic [DATA_W-1:0] AVAIL0 = IMPL_MASK,
  parameter logic [DATA_W-1:0] AVAIL1 = AV1_DEFAULT
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic [DATA_W-1:0] clkEnOut
);

  ctrlStb_t stb;

  pce_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busSel   (busSel),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .stb      (stb)
  );

  pce_datapath #(.AVAIL0(AVAIL0), .AVAIL1(AVAIL1)) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .stb   (stb),
    .wdata (busWdata),
    .rdata (busRdata),
    .enOut (clkEnOut)
  );

endmodule

// File: tb/tb_periph_clk_en_ctrl.sv
`timescale 1ns/1ps
module tb_periph_clk_en_ctrl;

  localparam logic [31:0] IMPL   = 32'h7813_4C4F;
  // Bench override: peripheral at bit 14 absent, stray reserved bit 5 set
  localparam logic [31:0] AV0P   = 32'h7813_0C6F;
  localparam logic [31:0] AV0EXP = 32'h7813_0C4F;
  localparam logic [31:0] AV1EXP = 32'hF006_FF70;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busWrite = 1'b0;
  logic [4:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [31:0] clkEnOut;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;
  logic [31:0] expEn = 32'h1;
  logic [31:0] lastRd = '0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sbq[$];
  bit rdFire = 1'b0;

  always #2.5 clk = ~clk;

  periph_clk_en_ctrl #(.AVAIL0(AV0P)) dut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .clkEnOut(clkEnOut)
  );

  // Monitor: a read accepted on a rising edge is compared at the next falling edge
  always @(posedge clk) rdFire <= busSel && !busWrite && rstN;

  always @(negedge clk) begin
    if (rdFire) begin
      item_t it;
      it = sbq.pop_front();
      vectors++;
      lastRd = it.exp;
      if (busRdata !== it.exp) begin
        miscompares++;
        $display("FAIL %s read: got %08h exp %08h", it.tag, busRdata, it.exp);
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: got %08h exp %08h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string tag);
    busSel = 1'b1; busWrite = 1'b0; busAddr = a;
    sbq.push_back('{exp, tag});
    @(negedge clk);
    busSel = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d, input string tag);
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    if (a == 5'h0C) expEn = expEn | (d & AV0EXP);
    if (a == 5'h10) expEn = expEn & ~d;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0; busWdata = '0;
    check(tag, clkEnOut, expEn);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R2 reset enables", clkEnOut, 32'h1);
    check("R2 reset rdata", busRdata, 32'h0);

    rd(5'h00, AV0EXP, "R7 avail word 0");
    rd(5'h04, AV1EXP, "R8 avail word 1");
    rd(5'h08, 32'h1, "R2 status after reset");

    wr(5'h0C, 32'hFFFF_FFFF, "R4 set all (R1 R9 masking)");
    check("R1 only implemented", clkEnOut & ~IMPL, 32'h0);
    check("R9 bit 14 unavailable", clkEnOut[14], 1'b0);
    rd(5'h08, expEn, "R6 status equals output");

    wr(5'h10, 32'h0000_000F, "R5 clear low nibble");
    wr(5'h0C, 32'h0, "R4 zero set no change");
    wr(5'h10, 32'h0, "R5 zero clear no change");
    wr(5'h10, 32'hFFFF_FFFF, "R5 clear all");
    wr(5'h0C, 32'h0000_4000, "R9 set unavailable bit");

    wr(5'h0C, 32'h0000_0041, "R4 set bits 0 and 6");
    wr(5'h00, 32'hFFFF_FFFF, "R10 write avail0");
    wr(5'h04, 32'h0, "R10 write avail1");
    wr(5'h08, 32'hFFFF_FFFF, "R10 write status");
    wr(5'h14, 32'hFFFF_FFFF, "R10 write unmapped");
    wr(5'h0D, 32'hFFFF_FFFF, "R10 unaligned set");
    wr(5'h11, 32'hFFFF_FFFF, "R10 unaligned clear");
    rd(5'h00, AV0EXP, "R10 avail0 unchanged");
    rd(5'h04, AV1EXP, "R10 avail1 unchanged");
    rd(5'h08, expEn, "R10 status unchanged");

    rd(5'h0C, 32'h0, "R3 set alias reads 0");
    rd(5'h10, 32'h0, "R3 clear alias reads 0");
    rd(5'h1C, 32'h0, "R3 unmapped reads 0");
    rd(5'h08, expEn, "R3 status offset");

    repeat (3) @(negedge clk);
    check("R11 rdata holds", busRdata, lastRd);

    for (int i = 0; i < 32; i++) begin
      wr(5'h0C, 32'h1 << i, "R4 walking set");
      wr(5'h10, 32'h1 << i, "R5 walking clear");
    end
    check("R6 output after walk", clkEnOut, expEn);

    wr(5'h0C, 32'h7800_0000, "R4 set top group");
    wr(5'h10, 32'h2000_0000, "R5 clear bit 29");
    rd(5'h08, expEn, "R6 final status");

    @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule